// File: doc/BRIEF.md
# Serial Line Controller with Buffered Queues and Hardware Handshake

This block is an asynchronous serial transceiver for an 8N1 line. Software, or a host state machine, uses a small register port. Writes to the data register queue bytes for transmission. Reads from the same register take received bytes in arrival order. Other registers hold the baud divisor, a fractional refinement of that divisor, and the control bits. Both directions are buffered by 16-entry queues, so the host can move bytes in bursts instead of one at a time.

The receive side raises `irq_rx` when its queue holds at least a chosen number of bytes. The same fill level can drive the outgoing request-to-send pin, which throttles the remote sender. The incoming clear-to-send pin can hold back the local transmitter between characters. The baud tick comes from an integer divisor, and a fractional stage inserts single stall cycles evenly over time. This lets standard rates be reached from awkward input clocks.

Register map, indexed by `addr`:
- 0: data
- 1: divisor low byte
- 2: divisor high byte
- 3: fraction
- 4: control
- 5: status (read only)

Top module: `uart_fc`

## Requirements
- R1: After reset, the outputs and registers take these values:
  - `txd` = 1, `rts_n` = 0 and `irq_rx` = 0.
  - Status (addr 5) reads 0x30.
  - The divisor is 1, the fraction register holds MUL = 1 and ADD = 0, and control is 0.
- R2: A character is sent as follows:
  - The line goes low for one start bit.
  - Eight data bits follow, least significant bit first, then one high stop bit.
  - Every bit lasts 16 baud ticks.
  - With ADD = 0, a tick comes every divisor clocks (divisor = {addr 2, addr 1}, where 0 acts as 1). A divisor of 2 therefore gives 32-clock bits.
- R3: The fraction register (addr 3) holds MUL in bits [7:4] and ADD in bits [3:0].
  - When 1 ≤ MUL ≤ 15 and ADD < MUL, the tick period averages divisor × (1 + ADD/MUL) clocks, with the extra clocks inserted one at a time.
  - Any other setting leaves the fraction unused.
  - Divisor 1 with MUL = 2 and ADD = 1 gives 24-clock bits.
- R4: Bytes written to addr 0 are transmitted in write order. Received bytes are read from addr 0 in arrival order, and each read removes one byte. Both queues hold 16 bytes.
- R5: Control bits [1:0] choose the receive trigger level: 0 → 1, 1 → 4, 2 → 8, 3 → 14 bytes. `irq_rx` and status bit 6 are high while the receive queue holds at least that many bytes.
- R6: A write to addr 0 while the transmit queue holds 16 bytes is dropped. It sets status bit 3, which stays set until status is read.
- R7: A byte received while the receive queue is full is discarded, and the stored bytes are kept. Status bit 2 is set and stays set until status is read.
- R8: With control bit 2 set, no new character starts while `cts_n` is high.
- R9: A character that has already started is always sent to its end, even if `cts_n` rises partway through it.
- R10: With control bit 3 set:
  - `rts_n` goes high one cycle after the receive queue reaches the trigger level.
  - `rts_n` goes low one cycle after the queue falls below that level.
  - With control bit 3 clear, `rts_n` stays low.
- R11: The receiver treats only a high-to-low transition of `rxd` as a possible start bit. It drops that start if `rxd` is high again 8 ticks later, at mid-bit.
- R12: A character whose stop bit samples low is still stored, marked with a framing error.
  - Status bit 1 shows the mark of the byte at the head of the receive queue.
  - Status bit 0 = receive queue not empty.
  - Status bit 4 = transmit queue empty.
  - Status bit 5 = transmitter fully idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 3 | Register index |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe (pops the receive queue at addr 0, clears the sticky flags at addr 5) |
| rd_data | output | 8 | Register read data, combinational from `addr` |
| irq_rx | output | 1 | Receive queue at or above the trigger level |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line (asynchronous) |
| cts_n | input | 1 | Clear-to-send, active low (asynchronous) |
| rts_n | output | 1 | Request-to-send, active low |

## Verification
The properties assume these things about the inputs:
- The host keeps the register port quiet while it changes the divisor or the fraction.
- The host raises at most one of `wr_en` and `rd_en` per cycle.
- `rxd` and `cts_n` reach the logic only through the synchronizers.

The bench drives every register access on the falling clock edge, one access per cycle with idle cycles between. It changes baud settings only while both queues are empty and the line is quiet. When it drives `rxd` by hand, it holds every level for whole bit times at the programmed rate, except for the deliberate short glitch.

// File: rtl/uart_fc_pkg.sv
package uart_fc_pkg;

   localparam int OVS   = 16;
   localparam int OVS_W = $clog2(OVS);

   localparam logic [2:0] A_DATA = 3'd0;
   localparam logic [2:0] A_DIVL = 3'd1;
   localparam logic [2:0] A_DIVH = 3'd2;
   localparam logic [2:0] A_FRAC = 3'd3;
   localparam logic [2:0] A_CTRL = 3'd4;
   localparam logic [2:0] A_STAT = 3'd5;

   typedef enum logic [1:0] {
      LN_IDLE,
      LN_START,
      LN_DATA,
      LN_STOP
   } line_st_e;

   typedef struct packed {
      logic       auto_rts;
      logic       auto_cts;
      logic [1:0] trig_sel;
   } ctrl_t;

   function automatic int unsigned trig_level(input logic [1:0] sel);
      case (sel)
         2'd0:    return 1;
         2'd1:    return 4;
         2'd2:    return 8;
         default: return 14;
      endcase
   endfunction

endpackage

// File: rtl/uart_fc_fifo.sv
module uart_fc_fifo #(
   parameter int WIDTH = 8,
   parameter int DEPTH = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push,
   input  logic [WIDTH-1:0] din,
   input  logic             pop,
   output logic [WIDTH-1:0] dout,
   output logic [CW-1:0]    count,
   output logic             full,
   output logic             empty
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("uart_fc_fifo: DEPTH must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("uart_fc_fifo: WIDTH must be positive");
   end

   logic [WIDTH-1:0] mem [DEPTH];
   logic [AW-1:0]    wptr, rptr;
   logic             do_push, do_pop;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign do_push = push && !full;
   assign do_pop  = pop && !empty;
   assign dout    = mem[rptr];

   function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
      return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
   endfunction

   always_ff @(posedge clk) begin
      if (do_push) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (do_push) wptr <= bump(wptr);
         if (do_pop)  rptr <= bump(rptr);
         case ({do_push, do_pop})
            2'b10:   count <= count + CW'(1);
            2'b01:   count <= count - CW'(1);
            default: count <= count;
         endcase
      end
   end

endmodule

// File: rtl/uart_fc_baud.sv
module uart_fc_baud #(
   parameter int DIV_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [DIV_W-1:0] divisor,
   input  logic [3:0]       mulval,
   input  logic [3:0]       divadd,
   output logic             tick
);

   logic [DIV_W-1:0] cnt;
   logic [DIV_W-1:0] div_m1;
   logic [4:0]       acc, acc_nxt, mul_eff;
   logic [3:0]       add_eff;
   logic             stall, frac_ok;

   assign frac_ok = (mulval != 4'd0) && (divadd < mulval);
   assign add_eff = frac_ok ? divadd : 4'd0;
   assign mul_eff = frac_ok ? {1'b0, mulval} : 5'd1;
   assign acc_nxt = acc + {1'b0, add_eff};
   assign div_m1  = (divisor == '0) ? '0 : divisor - DIV_W'(1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         acc   <= '0;
         stall <= 1'b0;
         tick  <= 1'b0;
      end else if (restart) begin
         cnt   <= '0;
         acc   <= '0;
         stall <= 1'b0;
         tick  <= 1'b0;
      end else begin
         tick <= 1'b0;
         if (stall) begin
            stall <= 1'b0;
         end else begin
            if (cnt >= div_m1) begin
               cnt  <= '0;
               tick <= 1'b1;
            end else begin
               cnt <= cnt + DIV_W'(1);
            end
            if (acc_nxt >= mul_eff) begin
               acc   <= acc_nxt - mul_eff;
               stall <= 1'b1;
            end else begin
               acc <= acc_nxt;
            end
         end
      end
   end

endmodule

// File: rtl/uart_fc_tx.sv
module uart_fc_tx
   import uart_fc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       avail,
   input  logic [7:0] data,
   input  logic       cts_block,
   output logic       pop,
   output logic       txd,
   output logic       busy
);

   line_st_e         state;
   logic [OVS_W-1:0] sub;
   logic [2:0]       bitn;
   logic [7:0]       shreg;
   logic             bit_end;

   assign pop     = tick && (state == LN_IDLE) && avail && !cts_block;
   assign busy    = (state != LN_IDLE);
   assign bit_end = (sub == OVS_W'(OVS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LN_IDLE;
         sub   <= '0;
         bitn  <= '0;
         shreg <= '0;
         txd   <= 1'b1;
      end else if (tick) begin
         case (state)
            LN_IDLE: begin
               if (pop) begin
                  shreg <= data;
                  sub   <= '0;
                  txd   <= 1'b0;
                  state <= LN_START;
               end
            end
            LN_START: begin
               sub <= sub + OVS_W'(1);
               if (bit_end) begin
                  txd   <= shreg[0];
                  shreg <= {1'b0, shreg[7:1]};
                  bitn  <= '0;
                  state <= LN_DATA;
               end
            end
            LN_DATA: begin
               sub <= sub + OVS_W'(1);
               if (bit_end) begin
                  if (bitn == 3'd7) begin
                     txd   <= 1'b1;
                     state <= LN_STOP;
                  end else begin
                     txd   <= shreg[0];
                     shreg <= {1'b0, shreg[7:1]};
                     bitn  <= bitn + 3'd1;
                  end
               end
            end
            default: begin
               sub <= sub + OVS_W'(1);
               if (bit_end) state <= LN_IDLE;
            end
         endcase
      end
   end

endmodule

// File: rtl/uart_fc_rx.sv
module uart_fc_rx
   import uart_fc_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   output logic       valid,
   output logic [7:0] data,
   output logic       ferr
);

   line_st_e         state;
   logic [OVS_W-1:0] sub;
   logic [2:0]       bitn;
   logic [7:0]       shreg;
   logic             prev;
   logic             bit_mid;
   logic             start_mid;

   assign bit_mid   = (sub == OVS_W'(OVS - 1));
   assign start_mid = (sub == OVS_W'(OVS / 2 - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= LN_IDLE;
         sub   <= '0;
         bitn  <= '0;
         shreg <= '0;
         prev  <= 1'b1;
         valid <= 1'b0;
         data  <= '0;
         ferr  <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (tick) begin
            prev <= rxd;
            case (state)
               LN_IDLE: begin
                  if (prev && !rxd) begin
                     sub   <= '0;
                     state <= LN_START;
                  end
               end
               LN_START: begin
                  if (start_mid) begin
                     sub  <= '0;
                     bitn <= '0;
                     state <= rxd ? LN_IDLE : LN_DATA;
                  end else begin
                     sub <= sub + OVS_W'(1);
                  end
               end
               LN_DATA: begin
                  sub <= sub + OVS_W'(1);
                  if (bit_mid) begin
                     shreg <= {rxd, shreg[7:1]};
                     if (bitn == 3'd7) state <= LN_STOP;
                     else              bitn  <= bitn + 3'd1;
                  end
               end
               default: begin
                  sub <= sub + OVS_W'(1);
                  if (bit_mid) begin
                     valid <= 1'b1;
                     data  <= shreg;
                     ferr  <= !rxd;
                     state <= LN_IDLE;
                  end
               end
            endcase
         end
      end
   end

endmodule

// File: rtl/uart_fc.sv
module uart_fc
   import uart_fc_pkg::*;
#(
   parameter int FIFO_DEPTH  = 16,
   parameter int DIV_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] addr,
   input  logic       wr_en,
   input  logic [7:0] wr_data,
   input  logic       rd_en,
   output logic [7:0] rd_data,
   output logic       irq_rx,
   output logic       txd,
   input  logic       rxd,
   input  logic       cts_n,
   output logic       rts_n
);

   localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

   if (FIFO_DEPTH < 16) begin : g_bad_depth
      $error("uart_fc: FIFO_DEPTH must reach the highest trigger level");
   end
   if (DIV_W < 8 || DIV_W > 16) begin : g_bad_div
      $error("uart_fc: DIV_W must lie between 8 and 16");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("uart_fc: SYNC_STAGES must be at least 2");
   end

   // input synchronizers
   logic [SYNC_STAGES-1:0] rx_sync, cts_sync;
   logic                   rxd_s, cts_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rx_sync  <= '1;
         cts_sync <= '1;
      end else begin
         rx_sync  <= {rx_sync[SYNC_STAGES-2:0], rxd};
         cts_sync <= {cts_sync[SYNC_STAGES-2:0], cts_n};
      end
   end
   assign rxd_s  = rx_sync[SYNC_STAGES-1];
   assign cts_hi = cts_sync[SYNC_STAGES-1];

   // configuration registers
   logic [7:0]       div_lo;
   logic [7:0]       div_hi_rd;
   logic [DIV_W-1:0] divisor;
   logic [3:0]       mulval, divadd;
   ctrl_t            ctrl;
   logic             auto_cts_en, auto_rts_en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         div_lo <= 8'd1;
         mulval <= 4'd1;
         divadd <= 4'd0;
         ctrl   <= '0;
      end else if (wr_en) begin
         case (addr)
            A_DIVL:  div_lo <= wr_data;
            A_FRAC:  {mulval, divadd} <= wr_data;
            A_CTRL:  ctrl <= ctrl_t'(wr_data[3:0]);
            default: ;
         endcase
      end
   end

   if (DIV_W > 8) begin : g_div_wide
      logic [DIV_W-9:0] div_hi;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                       div_hi <= '0;
         else if (wr_en && addr == A_DIVH) div_hi <= wr_data[DIV_W-9:0];
      end
      assign divisor   = {div_hi, div_lo};
      assign div_hi_rd = 8'(div_hi);
   end else begin : g_div_narrow
      assign divisor   = div_lo;
      assign div_hi_rd = 8'd0;
   end

   assign auto_cts_en = ctrl.auto_cts;
   assign auto_rts_en = ctrl.auto_rts;

   // baud tick
   logic baud_tick, baud_restart;
   assign baud_restart = wr_en && (addr == A_DIVL || addr == A_DIVH || addr == A_FRAC);

   uart_fc_baud #(.DIV_W(DIV_W)) i_baud (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (baud_restart),
      .divisor (divisor),
      .mulval  (mulval),
      .divadd  (divadd),
      .tick    (baud_tick)
   );

   // transmit path
   logic             tx_wr, tx_pop, tx_full, tx_empty, tx_busy, tx_idle;
   logic [7:0]       tx_head;
   logic [CNT_W-1:0] tx_count;

   assign tx_wr = wr_en && (addr == A_DATA);

   uart_fc_fifo #(.WIDTH(8), .DEPTH(FIFO_DEPTH)) i_txq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (tx_wr),
      .din   (wr_data),
      .pop   (tx_pop),
      .dout  (tx_head),
      .count (tx_count),
      .full  (tx_full),
      .empty (tx_empty)
   );

   uart_fc_tx i_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (baud_tick),
      .avail     (!tx_empty),
      .data      (tx_head),
      .cts_block (auto_cts_en && cts_hi),
      .pop       (tx_pop),
      .txd       (txd),
      .busy      (tx_busy)
   );

   assign tx_idle = tx_empty && !tx_busy;

   // receive path
   logic             rx_valid, rx_ferr, rx_pop, rx_full, rx_empty;
   logic [7:0]       rx_byte;
   logic [8:0]       rx_head;
   logic [CNT_W-1:0] rx_count, trig_lvl;
   logic             lvl_hit;

   uart_fc_rx i_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (baud_tick),
      .rxd   (rxd_s),
      .valid (rx_valid),
      .data  (rx_byte),
      .ferr  (rx_ferr)
   );

   assign rx_pop = rd_en && (addr == A_DATA);

   uart_fc_fifo #(.WIDTH(9), .DEPTH(FIFO_DEPTH)) i_rxq (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (rx_valid),
      .din   ({rx_ferr, rx_byte}),
      .pop   (rx_pop),
      .dout  (rx_head),
      .count (rx_count),
      .full  (rx_full),
      .empty (rx_empty)
   );

   assign trig_lvl = CNT_W'(trig_level(ctrl.trig_sel));
   assign lvl_hit  = (rx_count >= trig_lvl);
   assign irq_rx   = lvl_hit;

   // sticky error flags and handshake output
   logic stat_rd, ovr_rx, ovf_tx, rts_q;
   assign stat_rd = rd_en && (addr == A_STAT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ovr_rx <= 1'b0;
         ovf_tx <= 1'b0;
         rts_q  <= 1'b0;
      end else begin
         if (rx_valid && rx_full) ovr_rx <= 1'b1;
         else if (stat_rd)        ovr_rx <= 1'b0;
         if (tx_wr && tx_full)    ovf_tx <= 1'b1;
         else if (stat_rd)        ovf_tx <= 1'b0;
         rts_q <= auto_rts_en && lvl_hit;
      end
   end
   assign rts_n = rts_q;

   // read mux
   always_comb begin
      case (addr)
         A_DATA:  rd_data = rx_empty ? 8'd0 : rx_head[7:0];
         A_DIVL:  rd_data = div_lo;
         A_DIVH:  rd_data = div_hi_rd;
         A_FRAC:  rd_data = {mulval, divadd};
         A_CTRL:  rd_data = {4'd0, ctrl};
         A_STAT:  rd_data = {1'b0, lvl_hit, tx_idle, tx_empty, ovf_tx, ovr_rx,
                             rx_head[8] && !rx_empty, !rx_empty};
         default: rd_data = 8'd0;
      endcase
   end

endmodule

// File: rtl/uart_fc_chk.sv
module uart_fc_chk #(
   parameter int DEPTH = 16,
   parameter int CW    = 5,
   parameter int DIV_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tick,
   input logic [DIV_W-1:0] divisor,
   input logic             tx_busy,
   input logic             txd,
   input logic             auto_cts,
   input logic             cts_hi,
   input logic             auto_rts,
   input logic             rts_n,
   input logic [CW-1:0]    rx_count,
   input logic [CW-1:0]    trig_lvl,
   input logic             irq_rx,
   input logic             tx_wr,
   input logic [CW-1:0]    tx_count,
   input logic             tx_pop,
   input logic             rx_valid,
   input logic             rx_full,
   input logic             ovr_rx
);

   assert_idle_line_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> txd);

   assert_tick_gap_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && divisor >= DIV_W'(2)) |=> !tick);

   assert_rx_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
      rx_count <= CW'(DEPTH));

   assert_irq_nonempty_R5: assert property (@(posedge clk) disable iff (!rst_n)
      irq_rx |-> (rx_count != '0));

   assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_wr && tx_count == CW'(DEPTH) && !tx_pop) |=> (tx_count == CW'(DEPTH)));

   assert_overrun_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full) |=> ovr_rx);

   assert_cts_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_cts && cts_hi && !tx_busy) |=> !tx_busy);

   assert_rts_level_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (auto_rts && rx_count >= trig_lvl) |=> rts_n);

   assert_rts_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !auto_rts |=> !rts_n);

endmodule

bind uart_fc uart_fc_chk #(
   .DEPTH (FIFO_DEPTH),
   .CW    (CNT_W),
   .DIV_W (DIV_W)
) i_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .tick     (baud_tick),
   .divisor  (divisor),
   .tx_busy  (tx_busy),
   .txd      (txd),
   .auto_cts (auto_cts_en),
   .cts_hi   (cts_hi),
   .auto_rts (auto_rts_en),
   .rts_n    (rts_n),
   .rx_count (rx_count),
   .trig_lvl (trig_lvl),
   .irq_rx   (irq_rx),
   .tx_wr    (tx_wr),
   .tx_count (tx_count),
   .tx_pop   (tx_pop),
   .rx_valid (rx_valid),
   .rx_full  (rx_full),
   .ovr_rx   (ovr_rx)
);

// File: tb/test_uart_fc.sv
module test_uart_fc;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] addr = '0;
   logic       wr_en = 1'b0;
   logic [7:0] wr_data = '0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_data;
   logic       irq_rx, txd, rts_n;
   logic       rxd;
   logic       cts_n = 1'b0;
   logic       loop_on = 1'b1;
   logic       rxd_drv = 1'b1;

   int total = 0;
   int bad   = 0;

   localparam int FRAME = 200;

   always #5 clk = ~clk;

   assign rxd = loop_on ? txd : rxd_drv;

   uart_fc i_uart_fc (
      .clk     (clk),
      .rst_n   (rst_n),
      .addr    (addr),
      .wr_en   (wr_en),
      .wr_data (wr_data),
      .rd_en   (rd_en),
      .rd_data (rd_data),
      .irq_rx  (irq_rx),
      .txd     (txd),
      .rxd     (rxd),
      .cts_n   (cts_n),
      .rts_n   (rts_n)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #1 d = rd_data;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic cfg(input logic [7:0] div, input logic [7:0] frac, input logic [7:0] ctl);
      wr_reg(3'd1, div);
      wr_reg(3'd2, 8'd0);
      wr_reg(3'd3, frac);
      wr_reg(3'd4, ctl);
   endtask

   task automatic drain();
      logic [7:0] s, d;
      for (int i = 0; i < 20; i++) begin
         rd_reg(3'd5, s);
         if (s[0]) rd_reg(3'd0, d);
      end
   endtask

   task automatic capture_tx(input int bp, output logic [7:0] b, output logic st, output logic sp);
      @(negedge txd);
      wait_clk(bp / 2);
      st = txd;
      for (int i = 0; i < 8; i++) begin
         wait_clk(bp);
         b[i] = txd;
      end
      wait_clk(bp);
      sp = txd;
   endtask

   task automatic send_raw(input logic [7:0] b, input logic stop);
      @(negedge clk);
      rxd_drv = 1'b0;
      repeat (16) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd_drv = b[i];
         repeat (16) @(negedge clk);
      end
      rxd_drv = stop;
      repeat (16) @(negedge clk);
      rxd_drv = 1'b1;
   endtask

   task automatic t_reset();
      logic [7:0] s;
      chk(txd == 1'b1, "R1 txd idle", txd, 1);
      chk(rts_n == 1'b0, "R1 rts_n", rts_n, 0);
      chk(irq_rx == 1'b0, "R1 irq_rx", irq_rx, 0);
      rd_reg(3'd5, s);
      chk(s == 8'h30, "R1 status", s, 8'h30);
      rd_reg(3'd3, s);
      chk(s == 8'h10, "R1 fraction", s, 8'h10);
   endtask

   task automatic t_frame();
      logic [7:0] b, d;
      logic st, sp;
      cfg(8'd2, 8'h10, 8'h00);
      wr_reg(3'd0, 8'hA5);
      capture_tx(32, b, st, sp);
      chk(st == 1'b0, "R2 start bit", st, 0);
      chk(b == 8'hA5, "R2 data bits lsb first", b, 8'hA5);
      chk(sp == 1'b1, "R2 stop bit", sp, 1);
      wait_clk(400);
      rd_reg(3'd0, d);
      chk(d == 8'hA5, "R2 loopback", d, 8'hA5);
   endtask

   task automatic t_frac();
      logic [7:0] b, d;
      logic st, sp;
      int n;
      cfg(8'd1, 8'h21, 8'h00);
      wr_reg(3'd0, 8'h01);
      @(negedge txd);
      n = 0;
      while (txd == 1'b0 && n < 100) begin
         @(posedge clk); #1;
         n++;
      end
      chk(n >= 23 && n <= 25, "R3 fractional bit length", n, 24);
      wait_clk(300);
      wr_reg(3'd0, 8'h5A);
      capture_tx(24, b, st, sp);
      chk(b == 8'h5A && !st && sp, "R3 fractional frame", b, 8'h5A);
      wait_clk(300);
      rd_reg(3'd0, d);
      chk(d == 8'h01, "R3 rx first", d, 8'h01);
      rd_reg(3'd0, d);
      chk(d == 8'h5A, "R3 rx second", d, 8'h5A);
   endtask

   task automatic t_order();
      logic [7:0] pat [5] = '{8'h00, 8'hFF, 8'h3C, 8'hC3, 8'h81};
      logic [7:0] d;
      cfg(8'd1, 8'h10, 8'h00);
      foreach (pat[i]) wr_reg(3'd0, pat[i]);
      wait_clk(6 * FRAME);
      foreach (pat[i]) begin
         rd_reg(3'd0, d);
         chk(d == pat[i], "R4 order", d, pat[i]);
      end
      rd_reg(3'd5, d);
      chk(d[0] == 1'b0, "R4 empty after reads", d[0], 0);
   endtask

   task automatic t_trig();
      int lv [4] = '{1, 4, 8, 14};
      for (int s = 0; s < 4; s++) begin
         wr_reg(3'd4, 8'(s));
         for (int k = 0; k < lv[s] - 1; k++) wr_reg(3'd0, 8'(k));
         wait_clk(lv[s] * FRAME);
         chk(irq_rx == 1'b0, "R5 below level", irq_rx, 0);
         wr_reg(3'd0, 8'h77);
         wait_clk(FRAME + 50);
         chk(irq_rx == 1'b1, "R5 at level", irq_rx, 1);
         drain();
         chk(irq_rx == 1'b0, "R5 after drain", irq_rx, 0);
      end
      wr_reg(3'd4, 8'h00);
   endtask

   task automatic t_txfull();
      logic [7:0] s, d;
      cts_n = 1'b1;
      wr_reg(3'd4, 8'h04);
      wait_clk(5);
      for (int i = 0; i < 17; i++) wr_reg(3'd0, 8'(8'h10 + i));
      rd_reg(3'd5, s);
      chk(s[3] == 1'b1, "R6 overflow flag", s[3], 1);
      rd_reg(3'd5, s);
      chk(s[3] == 1'b0, "R6 flag cleared by read", s[3], 0);
      cts_n = 1'b0;
      wait_clk(17 * FRAME);
      for (int i = 0; i < 16; i++) begin
         rd_reg(3'd0, d);
         chk(d == 8'(8'h10 + i), "R6 kept bytes", d, 8'h10 + i);
      end
      rd_reg(3'd5, s);
      chk(s[0] == 1'b0, "R6 dropped byte absent", s[0], 0);
      wr_reg(3'd4, 8'h00);
   endtask

   task automatic t_overrun();
      logic [7:0] s, d;
      for (int i = 0; i < 16; i++) wr_reg(3'd0, 8'(8'h20 + i));
      wait_clk(17 * FRAME);
      wr_reg(3'd0, 8'hEE);
      wait_clk(FRAME + 100);
      rd_reg(3'd5, s);
      chk(s[2] == 1'b1, "R7 overrun flag", s[2], 1);
      for (int i = 0; i < 16; i++) begin
         rd_reg(3'd0, d);
         chk(d == 8'(8'h20 + i), "R7 stored bytes", d, 8'h20 + i);
      end
      rd_reg(3'd5, s);
      chk(s[0] == 1'b0 && s[2] == 1'b0, "R7 discarded and cleared", s, 8'h30);
   endtask

   task automatic t_cts();
      logic [7:0] s, d;
      int lows;
      cts_n = 1'b1;
      wr_reg(3'd4, 8'h04);
      wait_clk(5);
      wr_reg(3'd0, 8'h42);
      lows = 0;
      for (int i = 0; i < 400; i++) begin
         @(posedge clk); #1;
         if (txd == 1'b0) lows++;
      end
      chk(lows == 0, "R8 line held while cts high", lows, 0);
      rd_reg(3'd5, s);
      chk(s[4] == 1'b0, "R8 byte still queued", s[4], 0);
      cts_n = 1'b0;
      wait_clk(FRAME + 50);
      rd_reg(3'd0, d);
      chk(d == 8'h42, "R8 sent after release", d, 8'h42);
   endtask

   task automatic t_cts_mid();
      logic [7:0] s, d;
      cts_n = 1'b0;
      wr_reg(3'd0, 8'h99);
      wr_reg(3'd0, 8'h66);
      @(negedge txd);
      wait_clk(80);
      cts_n = 1'b1;
      wait_clk(2 * FRAME);
      rd_reg(3'd5, s);
      chk(s[0] == 1'b1, "R9 first byte arrived", s[0], 1);
      rd_reg(3'd0, d);
      chk(d == 8'h99, "R9 first byte intact", d, 8'h99);
      rd_reg(3'd5, s);
      chk(s[0] == 1'b0 && s[4] == 1'b0, "R9 second byte held", s, 8'h00);
      cts_n = 1'b0;
      wait_clk(FRAME + 50);
      rd_reg(3'd0, d);
      chk(d == 8'h66, "R9 second after release", d, 8'h66);
      wr_reg(3'd4, 8'h00);
   endtask

   task automatic t_rts();
      logic [7:0] d;
      wr_reg(3'd4, 8'h09);
      for (int i = 0; i < 3; i++) wr_reg(3'd0, 8'(i));
      wait_clk(4 * FRAME);
      chk(rts_n == 1'b0, "R10 below level", rts_n, 0);
      wr_reg(3'd0, 8'h33);
      wait_clk(FRAME + 50);
      chk(rts_n == 1'b1, "R10 deasserted at level", rts_n, 1);
      rd_reg(3'd0, d);
      wait_clk(2);
      chk(rts_n == 1'b0, "R10 reasserted below level", rts_n, 0);
      drain();
      wr_reg(3'd4, 8'h00);
   endtask

   task automatic t_glitch();
      logic [7:0] s, d;
      loop_on = 1'b0;
      @(negedge clk);
      rxd_drv = 1'b0;
      repeat (4) @(negedge clk);
      rxd_drv = 1'b1;
      wait_clk(300);
      rd_reg(3'd5, s);
      chk(s[0] == 1'b0, "R11 glitch rejected", s[0], 0);
      send_raw(8'h7E, 1'b1);
      wait_clk(60);
      rd_reg(3'd0, d);
      chk(d == 8'h7E, "R11 receiver recovers", d, 8'h7E);
   endtask

   task automatic t_ferr();
      logic [7:0] s, d;
      send_raw(8'h3C, 1'b0);
      wait_clk(60);
      rd_reg(3'd5, s);
      chk(s[1:0] == 2'b11, "R12 framing flag set", s[1:0], 3);
      rd_reg(3'd0, d);
      chk(d == 8'h3C, "R12 errored byte kept", d, 8'h3C);
      send_raw(8'h81, 1'b1);
      wait_clk(60);
      rd_reg(3'd5, s);
      chk(s[1:0] == 2'b01, "R12 clean byte flag", s[1:0], 1);
      rd_reg(3'd0, d);
      chk(d == 8'h81, "R12 clean byte", d, 8'h81);
      loop_on = 1'b1;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      wait_clk(2);
      t_reset();
      t_frame();
      t_frac();
      t_order();
      t_trig();
      t_txfull();
      t_overrun();
      t_cts();
      t_cts_mid();
      t_rts();
      t_glitch();
      t_ferr();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule